// File: doc/BRIEF.md
# Indirect Per-Peripheral Generated Clock Controller

This block keeps divided clock-enable settings for a bank of peripheral slots and produces one clock-enable strobe per slot. All slots sit behind one 32-bit control word. A write whose command bit is clear only points the read port at a slot. A write whose command bit is set carries a new source choice, divider and enable for the slot named in the same word.

Each slot picks one of several source strobes, divides it by N+1 with an integer counter, and gates the result with its enable bit. Source and divider changes take effect only while the slot is stopped. This lets software switch a running clock safely: it stops the slot, changes the settings, then starts it again. Everything runs in one system clock domain, and every clock is an enable strobe.

Top module: `gclk_ctrl`

Control word fields: slot ID in bits [5:0], source code in bits [10:8], command bit at bit 12, divider N in bits [23:16], enable at bit 28. All other bits are ignored on write and read as zero.

## Requirements
- R1: After reset every slot is stopped with source 0 and divider 0, and the selected ID is 0. With no write, `reg_rdata` reads 0 and `gclk_stb` is all zero.
- R2: Every write latches its ID field as the selected slot. A write with bit 12 clear changes no slot. From the next cycle, a valid selected ID reads back as: ID in [5:0], source in [10:8], divider in [23:16], enable in bit 28, and zeros in all other bits.
- R3: A write with bit 12 set to a stopped, valid slot stores its source, divider and enable fields. The stored values read back from the next cycle.
- R4: An enabled slot with source code s below the number of sources pulses its `gclk_stb` bit for one cycle on every (N+1)-th cycle in which `src_stb[s]` is high. The pulse comes in the same cycle as that source strobe. Counting restarts from zero each time the slot is enabled.
- R5: Source codes 6 and 7 select no source. An enabled slot with such a code never pulses.
- R6: Slot IDs 0 and 1 are invalid. Commits to them are ignored, a read of them returns 0, and `gclk_stb[1:0]` stays 0.
- R7: A commit to a running slot that keeps the enable bit set leaves its source and divider unchanged. The read-back and the output rate both show the old settings.
- R8: A commit that clears the enable bit stops the slot's pulses from the next cycle on. The slot keeps its stored source and divider, and these read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Configuration of the selected slot |
| src_stb | input | NUM_SRC | Source clock-enable strobes |
| gclk_stb | output | NUM_SLOTS | Per-slot divided clock-enable strobes |

## Verification
If a slot's divide counter is wrong, its strobe moves off the (N+1)-th source strobe within one divide period. The bench compares the whole output vector every cycle, so this shows up at once. If stored settings are wrong, or a slot takes a change while it runs, the next read-back of that slot shows the mismatch one cycle after selecting it. The rate checks catch the same fault as soon as the slot pulses. If the selected-ID register is stale, the very next read returns the wrong ID echo.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
   localparam int REG_W   = 32;
   localparam int ID_LSB  = 0;
   localparam int ID_W    = 6;
   localparam int SRC_LSB = 8;
   localparam int SRC_W   = 3;
   localparam int CMD_BIT = 12;
   localparam int DIV_LSB = 16;
   localparam int DIV_W   = 8;
   localparam int EN_BIT  = 28;

   typedef struct packed {
      logic             en;
      logic [SRC_W-1:0] src;
      logic [DIV_W-1:0] div;
   } slot_cfg_t;
endpackage

// File: rtl/gclk_regif.sv
module gclk_regif
   import gclk_pkg::*;
#(
   parameter int NUM_SLOTS = 64,
   parameter int MIN_ID    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   input  slot_cfg_t            cfg [NUM_SLOTS],
   output logic [REG_W-1:0]     reg_rdata,
   output logic [NUM_SLOTS-1:0] commit,
   output slot_cfg_t            new_cfg
);
   logic [ID_W-1:0] sel_id;
   logic [ID_W-1:0] wr_id;
   logic            sel_ok;
   slot_cfg_t       sel_cfg;
   logic            unused_wbits;

   assign wr_id        = reg_wdata[ID_LSB +: ID_W];
   assign new_cfg.en   = reg_wdata[EN_BIT];
   assign new_cfg.src  = reg_wdata[SRC_LSB +: SRC_W];
   assign new_cfg.div  = reg_wdata[DIV_LSB +: DIV_W];
   assign unused_wbits = ^{reg_wdata[31:29], reg_wdata[27:24], reg_wdata[15:13],
                           reg_wdata[11], reg_wdata[7:6]};

   always_ff @(posedge clk) begin
      if (!rst_n) sel_id <= '0;
      else if (reg_wr) sel_id <= wr_id;
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
      if (i < MIN_ID) begin : g_bad
         assign commit[i] = 1'b0;
      end else begin : g_ok
         assign commit[i] = reg_wr && reg_wdata[CMD_BIT] && (int'(wr_id) == i);
      end
   end

   always_comb begin
      sel_ok  = 1'b0;
      sel_cfg = '0;
      for (int k = MIN_ID; k < NUM_SLOTS; k++) begin
         if (int'(sel_id) == k) begin
            sel_ok  = 1'b1;
            sel_cfg = cfg[k];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ok) begin
         reg_rdata[ID_LSB +: ID_W]   = sel_id;
         reg_rdata[SRC_LSB +: SRC_W] = sel_cfg.src;
         reg_rdata[DIV_LSB +: DIV_W] = sel_cfg.div;
         reg_rdata[EN_BIT]           = sel_cfg.en;
      end
   end

   // R2
   id_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (sel_id == $past(wr_id)));
   // R6
   bad_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_id) < MIN_ID) |-> (reg_rdata == '0));
endmodule

// File: rtl/gclk_slot.sv
module gclk_slot
   import gclk_pkg::*;
#(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  slot_cfg_t          new_cfg,
   input  logic [NUM_SRC-1:0] src_stb,
   output slot_cfg_t          cfg,
   output logic               out_stb
);
   logic [DIV_W-1:0] cnt;
   logic             src_hit;
   logic             wrap;

   always_comb begin
      src_hit = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
         if (int'(cfg.src) == k) src_hit = src_stb[k];
   end

   assign wrap    = cfg.en && src_hit && (cnt == cfg.div);
   assign out_stb = wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
         cnt <= '0;
      end else begin
         if (commit) begin
            cfg.en <= new_cfg.en;
            if (!cfg.en) begin
               cfg.src <= new_cfg.src;
               cfg.div <= new_cfg.div;
            end
         end
         if (!cfg.en || wrap) cnt <= '0;
         else if (src_hit)    cnt <= cnt + 1'b1;
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.en |-> (cnt <= cfg.div));
   // R7
   run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && $past(cfg.en)) |-> ($stable(cfg.src) && $stable(cfg.div)));
   // R8
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !new_cfg.en) |=> !out_stb);
endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
   import gclk_pkg::*;
#(
   parameter int NUM_SLOTS = 64,
   parameter int NUM_SRC   = 6,
   parameter int MIN_ID    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic [NUM_SRC-1:0]   src_stb,
   output logic [NUM_SLOTS-1:0] gclk_stb
);
   if (NUM_SLOTS > (1 << ID_W) || NUM_SLOTS <= MIN_ID) begin : g_slots_bad
      $error("NUM_SLOTS out of range");
   end
   if (NUM_SRC < 1 || NUM_SRC > (1 << SRC_W)) begin : g_src_bad
      $error("NUM_SRC out of range");
   end

   slot_cfg_t            cfg [NUM_SLOTS];
   slot_cfg_t            new_cfg;
   logic [NUM_SLOTS-1:0] commit;

   gclk_regif #(.NUM_SLOTS(NUM_SLOTS), .MIN_ID(MIN_ID)) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .cfg(cfg), .reg_rdata(reg_rdata), .commit(commit), .new_cfg(new_cfg)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (i < MIN_ID) begin : g_none
         assign cfg[i]      = '0;
         assign gclk_stb[i] = 1'b0;
      end else begin : g_live
         gclk_slot #(.NUM_SRC(NUM_SRC)) u_slot (
            .clk(clk), .rst_n(rst_n), .commit(commit[i]), .new_cfg(new_cfg),
            .src_stb(src_stb), .cfg(cfg[i]), .out_stb(gclk_stb[i])
         );
      end
   end

   // R6
   bad_slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gclk_stb[MIN_ID-1:0] == '0);
endmodule

// File: tb/sim_gclk_ctrl.sv
module sim_gclk_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  src_stb = '0;
   logic [63:0] gclk_stb;

   int errors = 0;
   int checks = 0;
   int pulses = 0;
   int watch = 5;

   logic       m_en  [64];
   logic [2:0] m_src [64];
   logic [7:0] m_div [64];
   logic [7:0] m_cnt [64];
   logic [5:0] m_sel;

   always #10 clk = ~clk;

   gclk_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
                 .reg_rdata(reg_rdata), .src_stb(src_stb), .gclk_stb(gclk_stb));

   function automatic logic [31:0] mk(input int id, input int cmd, input int src,
                                      input int dv, input int en);
      logic [31:0] w = '0;
      w[5:0]   = 6'(id);
      w[12]    = 1'(cmd);
      w[10:8]  = 3'(src);
      w[23:16] = 8'(dv);
      w[28]    = 1'(en);
      return w;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [5:0] id);
      if (id < 2) return '0;
      return mk(int'(id), 0, int'(m_src[id]), int'(m_div[id]), int'(m_en[id]));
   endfunction

   function automatic logic [63:0] exp_stb(input logic [5:0] s);
      logic [63:0] v = '0;
      for (int i = 2; i < 64; i++)
         if (m_en[i] && m_src[i] < 6 && s[m_src[i]] && m_cnt[i] == m_div[i]) v[i] = 1'b1;
      return v;
   endfunction

   task automatic check(input logic ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cycle(input logic wr, input logic [31:0] d, input logic [5:0] s);
      logic [63:0] e;
      @(negedge clk);
      reg_wr = wr; reg_wdata = d; src_stb = s;
      #1;
      e = exp_stb(s);
      check(gclk_stb == e, "R4 strobe vector", gclk_stb, e);
      check(reg_rdata == exp_rd(m_sel), "R2 read-back", 64'(reg_rdata), 64'(exp_rd(m_sel)));
      if (gclk_stb[watch]) pulses++;
      for (int i = 2; i < 64; i++) begin
         if (!m_en[i] || e[i]) m_cnt[i] = '0;
         else if (m_src[i] < 6 && s[m_src[i]]) m_cnt[i] = m_cnt[i] + 8'd1;
      end
      if (wr) begin
         if (d[12] && d[5:0] >= 2) begin
            if (!m_en[d[5:0]]) begin
               m_src[d[5:0]] = d[10:8];
               m_div[d[5:0]] = d[23:16];
            end
            m_en[d[5:0]] = d[28];
         end
         m_sel = d[5:0];
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) begin
         m_en[i] = 1'b0; m_src[i] = '0; m_div[i] = '0; m_cnt[i] = '0;
      end
      m_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(reg_rdata == 32'h0, "R1 reset read", 64'(reg_rdata), 64'h0);
      check(gclk_stb == 64'h0, "R1 reset strobes", gclk_stb, 64'h0);
      cycle(1, mk(5, 0, 0, 0, 0), 6'h3f);
      cycle(0, 0, 6'h3f);
      check(reg_rdata == 32'h5, "R1 slot 5 reset config", 64'(reg_rdata), 64'h5);

      // R2 select-only write with fields set changes nothing
      cycle(1, mk(9, 0, 3, 77, 1), 0);
      cycle(0, 0, 0);
      check(reg_rdata == 32'h9, "R2 select leaves slot 9", 64'(reg_rdata), 64'h9);

      // R3 commit to stopped slot 5
      cycle(1, mk(5, 1, 2, 3, 1), 0);
      cycle(0, 0, 0);
      check(reg_rdata == mk(5, 0, 2, 3, 1), "R3 stored config", 64'(reg_rdata),
            64'(mk(5, 0, 2, 3, 1)));

      // R4 divide by 4 on source 2
      pulses = 0;
      for (int k = 0; k < 8; k++) cycle(0, 0, 6'b000100);
      check(pulses == 2, "R4 pulses per 8 strobes", 64'(pulses), 64'd2);

      // R7 change while running is ignored
      cycle(1, mk(5, 1, 1, 0, 1), 0);
      cycle(0, 0, 0);
      check(reg_rdata == mk(5, 0, 2, 3, 1), "R7 settings frozen", 64'(reg_rdata),
            64'(mk(5, 0, 2, 3, 1)));
      pulses = 0;
      for (int k = 0; k < 4; k++) cycle(0, 0, 6'b000010);
      check(pulses == 0, "R7 old source kept", 64'(pulses), 64'd0);

      // R8 stop keeps settings
      cycle(1, mk(5, 1, 0, 0, 0), 6'b000100);
      pulses = 0;
      for (int k = 0; k < 6; k++) cycle(0, 0, 6'b111111);
      check(pulses == 0, "R8 stopped slot quiet", 64'(pulses), 64'd0);
      check(reg_rdata == mk(5, 0, 2, 3, 0), "R8 settings kept", 64'(reg_rdata),
            64'(mk(5, 0, 2, 3, 0)));

      // R5 idle source codes
      watch = 7;
      cycle(1, mk(7, 1, 6, 0, 1), 0);
      pulses = 0;
      for (int k = 0; k < 5; k++) cycle(0, 0, 6'b111111);
      check(pulses == 0, "R5 code 6 idle", 64'(pulses), 64'd0);
      cycle(1, mk(7, 1, 0, 0, 0), 0);
      cycle(1, mk(7, 1, 7, 0, 1), 0);
      pulses = 0;
      for (int k = 0; k < 5; k++) cycle(0, 0, 6'b111111);
      check(pulses == 0, "R5 code 7 idle", 64'(pulses), 64'd0);

      // R6 invalid slots
      watch = 1;
      cycle(1, mk(1, 1, 0, 0, 1), 0);
      cycle(1, mk(0, 1, 0, 0, 1), 0);
      cycle(1, mk(1, 0, 0, 0, 0), 0);
      pulses = 0;
      for (int k = 0; k < 4; k++) cycle(0, 0, 6'b111111);
      check(pulses == 0, "R6 slot 1 idle", 64'(pulses), 64'd0);
      check(reg_rdata == 32'h0, "R6 invalid read", 64'(reg_rdata), 64'h0);
      check(gclk_stb[1:0] == 2'b00, "R6 low slots", 64'(gclk_stb[1:0]), 64'h0);

      // R4 divider at maximum and restart on enable
      watch = 20;
      cycle(1, mk(20, 1, 0, 255, 1), 0);
      pulses = 0;
      for (int k = 0; k < 512; k++) cycle(0, 0, 6'b000001);
      check(pulses == 2, "R4 divide by 256", 64'(pulses), 64'd2);

      // random mix
      watch = 5;
      for (int k = 0; k < 4000; k++) begin
         logic wr;
         logic [31:0] d;
         wr = ($urandom % 4) == 0;
         d = mk($urandom % 64, $urandom % 2, $urandom % 8,
                (($urandom % 8) == 0) ? 255 : int'($urandom % 4), $urandom % 2);
         cycle(wr, d, 6'($urandom));
      end
      finish_run();
   end
endmodule